// File: doc/BRIEF.md
# Paged 32-bit Register Bridge over a 16-bit Management Bus

This block lets a requester read and write 32-bit registers inside a remote device that can only be reached through 16-bit management-bus accesses at one fixed PHY address. Each requester transaction becomes a strict sequence of three single accesses, issued to a downstream single-access master that completes each one with an acknowledge.

The first access writes a page number to a page-select register. The next two accesses move the two 16-bit halves of the data. The low half uses a register picked by a few address bits, and the high half always uses one fixed register. On a read, the block builds the 32-bit result from the two halves it fetched. On a write, it splits the requester's data into the two halves. If any access reports an error, the sequence stops at once and the block returns an error response.

The requester side is a valid/ready request plus a one-cycle completion pulse. Only one transaction is in flight at a time.

Top module: `mdio_page_bridge`

## Requirements
- R1: During and after reset, before any request is accepted, `req_ready` is 1, `acc_req` is 0 and `rsp_done` is 0.
- R2: Every downstream access uses PHY address 0x1F.
- R3: The first access of every transaction is a write to register 0x1F. Its data is request address bits 15:6, zero-extended to 16 bits. It is presented in the cycle after the request is accepted.
- R4: A read performs two more accesses, in this order. First it reads the register numbered by address bits 5:2 (0 to 15). Then it reads register 0x10.
- R5: A completed read returns `rsp_rdata` = {data from register 0x10, data from the low register}, with the high register in bits 31:16. A write returns `rsp_rdata` = 0.
- R6: A write performs two more accesses, in this order. First it writes `req_wdata[15:0]` to the register numbered by address bits 5:2. Then it writes `req_wdata[31:16]` to register 0x10.
- R7: If an acknowledge arrives with `acc_err` = 1, no further access of that transaction is made. The block then responds with `rsp_error` = 1 and `rsp_rdata` = 0. An error-free transaction responds with `rsp_error` = 0.
- R8: Address bits 1:0 and 31:16 have no effect on any access.
- R9: `req_ready` is 0 from acceptance until completion. `rsp_done` is a one-cycle pulse in the cycle after the final acknowledge, and `req_ready` is 1 in that same cycle.
- R10: While `acc_req` is 1 and no acknowledge has arrived, the register number, write flag and write data do not change.
- R11: An acknowledge that arrives while no access is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge idle, request can be taken |
| req_addr | input | 32 | Remote 32-bit register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion ended by an access error |
| rsp_rdata | output | 32 | Assembled read data |
| acc_req | output | 1 | Downstream access request, held until acknowledged |
| acc_write | output | 1 | Downstream access is a write |
| acc_phy | output | 5 | Downstream PHY address |
| acc_reg | output | 5 | Downstream register number |
| acc_wdata | output | 16 | Downstream write data |
| acc_ack | input | 1 | Downstream access complete |
| acc_err | input | 1 | Downstream access failed (valid with ack) |
| acc_rdata | input | 16 | Downstream read data (valid with ack) |

## Verification
Two things can happen in the same cycle: the completion pulse for one transaction and the acceptance of the next request. The bench provokes this by holding `req_valid` high with a second request while the first is still running. It then checks that `rsp_done` and `req_ready` are both 1 in one cycle and that the completion still carries the first transaction's result. In the following cycle, it checks that the page-select write of the second transaction is presented with the second address's page. A stray acknowledge while idle is injected separately to show that it starts nothing.

// File: rtl/mpb_pkg.sv
// Shared definitions for the paged register bridge.
// Assumes a 16-bit management bus with 5-bit PHY and register numbers.
package mpb_pkg;
    localparam int REG_W  = 5;
    localparam int HALF_W = 16;

    // Step of the three-access sequence; order is the issue order.
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_PAGE = 2'd1,
        STEP_LOW  = 2'd2,
        STEP_HIGH = 2'd3
    } mpb_step_e;
endpackage

// File: rtl/mpb_addr_split.sv
// Splits a remote register address into the page-select word and the
// number of the register that carries the low half-word.
// Assumes the page and index fields fit the bus widths.
module mpb_addr_split #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 6,
    parameter int PAGE_W   = 10,
    parameter int IDX_LSB  = 2,
    parameter int IDX_W    = 4
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic [mpb_pkg::HALF_W-1:0] page_word,
    output logic [mpb_pkg::REG_W-1:0]  low_reg
);
    localparam int PAGE_PAD = mpb_pkg::HALF_W - PAGE_W;
    localparam int IDX_PAD  = mpb_pkg::REG_W - IDX_W;

    // Zero-extend the page field to a bus word.
    always_comb begin
        page_word = {{PAGE_PAD{1'b0}}, addr[PAGE_LSB +: PAGE_W]};
    end

    // Zero-extend the index field to a register number.
    always_comb begin
        low_reg = {{IDX_PAD{1'b0}}, addr[IDX_LSB +: IDX_W]};
    end
endmodule

// File: rtl/mpb_seq.sv
// Sequencer: walks page, low and high accesses, aborts on an access
// error and raises a one-cycle completion. Assumes ack is only
// meaningful while an access is presented.
module mpb_seq (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               acc_ack,
    input  logic               acc_err,
    output mpb_pkg::mpb_step_e step,
    output logic               idle,
    output logic               done,
    output logic               error
);
    import mpb_pkg::*;

    logic busy;
    logic last_ack;

    // Decode whether an access is pending and whether this ack finishes.
    always_comb begin
        busy     = (step != STEP_IDLE);
        last_ack = busy && acc_ack && (acc_err || step == STEP_HIGH);
        idle     = !busy;
    end

    // Advance the step on each acknowledge; finish on error or last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= STEP_IDLE;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    step <= STEP_PAGE;
                end
            end else if (acc_ack) begin
                if (last_ack) begin
                    step  <= STEP_IDLE;
                    done  <= 1'b1;
                    error <= acc_err;
                end else begin
                    step <= mpb_step_e'(step + 2'd1);
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_IDLE) && !start |=> (step == STEP_IDLE) && !done); // R11
endmodule

// File: rtl/mpb_data.sv
// Data path: keeps the write data, supplies the half-word for each data
// step, keeps the low half of a read and builds the 32-bit response.
// Assumes the sequencer step and the ack are presented together.
module mpb_data #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [DATA_W-1:0]          wdata_in,
    input  logic                       is_write,
    input  mpb_pkg::mpb_step_e         step,
    input  logic                       acc_ack,
    input  logic                       acc_err,
    input  logic [mpb_pkg::HALF_W-1:0] acc_rdata,
    output logic [mpb_pkg::HALF_W-1:0] half_out,
    output logic [DATA_W-1:0]          rdata
);
    import mpb_pkg::*;

    localparam int HW = HALF_W;

    logic [DATA_W-1:0] wdata_q;
    logic [HW-1:0]     low_q;
    logic              good_ack;

    // Acknowledge of a data step that reported no error.
    always_comb begin
        good_ack = acc_ack && !acc_err;
    end

    // Pick the half-word to send in the current data step.
    always_comb begin
        half_out = '0;
        if (is_write) begin
            if (step == STEP_LOW) begin
                half_out = wdata_q[HW-1:0];
            end else if (step == STEP_HIGH) begin
                half_out = wdata_q[2*HW-1:HW];
            end
        end
    end

    // Hold the request write data for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (load) begin
            wdata_q <= wdata_in;
        end
    end

    // Keep the low half of a read until the high half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (step == STEP_LOW && good_ack) begin
            low_q <= acc_rdata;
        end
    end

    // Build the response word at completion; zero for writes and errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (step != STEP_IDLE && acc_ack && (acc_err || step == STEP_HIGH)) begin
            if (good_ack && !is_write) begin
                rdata <= {acc_rdata, low_q};
            end else begin
                rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/mdio_page_bridge.sv
// Top of the paged register bridge. Turns one 32-bit register request
// into page-select, low and high 16-bit accesses at a fixed PHY address.
// Assumes a downstream master that holds each access until it pulses ack.
module mdio_page_bridge #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          PAGE_LSB = 6,
    parameter int          PAGE_W   = 10,
    parameter int          IDX_LSB  = 2,
    parameter int          IDX_W    = 4,
    parameter logic [4:0]  PHY_NUM  = 5'h1F,
    parameter logic [4:0]  PAGE_REG = 5'h1F,
    parameter logic [4:0]  HIGH_REG = 5'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              acc_req,
    output logic              acc_write,
    output logic [4:0]        acc_phy,
    output logic [4:0]        acc_reg,
    output logic [15:0]       acc_wdata,
    input  logic              acc_ack,
    input  logic              acc_err,
    input  logic [15:0]       acc_rdata
);
    import mpb_pkg::*;

    mpb_step_e         step;
    logic              idle;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [HALF_W-1:0] page_word;
    logic [REG_W-1:0]  low_reg;
    logic [HALF_W-1:0] data_half;

    // Take a request only while idle.
    always_comb begin
        req_ready = idle;
        accept    = req_valid && idle;
    end

    // Latch address and direction of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
        end
    end

    mpb_addr_split #(
        .ADDR_W  (ADDR_W),
        .PAGE_LSB(PAGE_LSB),
        .PAGE_W  (PAGE_W),
        .IDX_LSB (IDX_LSB),
        .IDX_W   (IDX_W)
    ) u_split (
        .addr     (addr_q),
        .page_word(page_word),
        .low_reg  (low_reg)
    );

    mpb_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .acc_ack(acc_ack),
        .acc_err(acc_err),
        .step   (step),
        .idle   (idle),
        .done   (rsp_done),
        .error  (rsp_error)
    );

    mpb_data #(
        .DATA_W(DATA_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .wdata_in (req_wdata),
        .is_write (write_q),
        .step     (step),
        .acc_ack  (acc_ack),
        .acc_err  (acc_err),
        .acc_rdata(acc_rdata),
        .half_out (data_half),
        .rdata    (rsp_rdata)
    );

    // Present the access that belongs to the current step.
    always_comb begin
        acc_req   = !idle;
        acc_phy   = PHY_NUM;
        acc_write = 1'b0;
        acc_reg   = '0;
        acc_wdata = '0;
        case (step)
            STEP_PAGE: begin
                acc_write = 1'b1;
                acc_reg   = PAGE_REG;
                acc_wdata = page_word;
            end
            STEP_LOW: begin
                acc_write = write_q;
                acc_reg   = low_reg;
                acc_wdata = data_half;
            end
            STEP_HIGH: begin
                acc_write = write_q;
                acc_reg   = HIGH_REG;
                acc_wdata = data_half;
            end
            default: ;
        endcase
    end

    AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> acc_req && acc_write && (acc_reg == PAGE_REG)); // R3
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ack && acc_err |=> !acc_req && rsp_done && rsp_error); // R7
    AST_ACCESS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_ack |=> acc_req && $stable(acc_reg) && $stable(acc_write)
                                && $stable(acc_wdata)); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> $stable(addr_q)); // R8
    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ack && write_q |=> rsp_rdata == '0 || !rsp_done); // R5
endmodule

// File: tb/mdio_page_bridge_bench.sv
module mdio_page_bridge_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [31:0] wdata;
        logic [1:0]  fail;
        logic [1:0]  lat;
    } vec_t;

    // fail: 0 = no error, n = error on access n; lat: cycles before ack
    localparam vec_t VEC [10] = '{
        '{32'h0000_0044, 1'b0, 32'h0,          2'd0, 2'd0},
        '{32'h0000_7FFC, 1'b0, 32'h0,          2'd0, 2'd1},
        '{32'h0000_0003, 1'b0, 32'h0,          2'd0, 2'd0}, // R8 low bits
        '{32'hFFFF_FFC7, 1'b0, 32'h0,          2'd0, 2'd2}, // R8 high bits
        '{32'h0000_1230, 1'b1, 32'hDEAD_BEEF,  2'd0, 2'd0},
        '{32'hABCD_000B, 1'b1, 32'h0000_FFFF,  2'd0, 2'd1}, // R8
        '{32'h0000_0100, 1'b0, 32'h0,          2'd2, 2'd0},
        '{32'h0000_0040, 1'b1, 32'h1234_5678,  2'd1, 2'd1},
        '{32'h0000_0080, 1'b0, 32'h0,          2'd3, 2'd1},
        '{32'h0000_2FC8, 1'b1, 32'hCAFE_0001,  2'd3, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, rsp_error;
    logic [31:0] rsp_rdata;
    logic        acc_req, acc_write;
    logic [4:0]  acc_phy, acc_reg;
    logic [15:0] acc_wdata;
    logic        acc_ack = 1'b0;
    logic        acc_err = 1'b0;
    logic [15:0] acc_rdata = '0;

    int          n_chk = 0;
    int          n_fail = 0;
    int          n_acc = 0;
    int          fail_at = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    int          stab_bad = 0;
    bit          stray = 1'b0;
    logic [15:0] cur_page = '0;
    logic [4:0]  log_phy [3];
    logic [4:0]  log_reg [3];
    logic        log_wr  [3];
    logic [15:0] log_wd  [3];
    logic [4:0]  snap_reg;
    logic        snap_wr;
    logic [15:0] snap_wd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_page_bridge u_mdio_page_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .acc_req(acc_req), .acc_write(acc_write), .acc_phy(acc_phy),
        .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata)
    );

    function automatic logic [15:0] remote_val(input logic [15:0] pg, input logic [4:0] r);
        if (r == 5'h10) return pg + 16'h1357;
        return pg ^ {r, 11'h2A5};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Downstream single-access model, driven at the falling edge.
    always @(negedge clk) begin
        if (acc_ack) begin
            acc_ack = 1'b0;
            acc_err = 1'b0;
        end else if (stray) begin
            acc_ack = 1'b1;
            stray   = 1'b0;
        end else if (acc_req) begin
            if (wait_cnt == 0) begin
                snap_reg = acc_reg; snap_wr = acc_write; snap_wd = acc_wdata;
            end else if (snap_reg != acc_reg || snap_wr != acc_write || snap_wd != acc_wdata) begin
                stab_bad++;
            end
            if (wait_cnt >= lat) begin
                if (n_acc < 3) begin
                    log_phy[n_acc] = acc_phy; log_reg[n_acc] = acc_reg;
                    log_wr[n_acc]  = acc_write; log_wd[n_acc] = acc_wdata;
                end
                if (acc_write && acc_reg == 5'h1F) cur_page = acc_wdata;
                acc_rdata = acc_write ? 16'h0 : remote_val(cur_page, acc_reg);
                n_acc++;
                acc_err  = (n_acc == fail_at);
                acc_ack  = 1'b1;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic run_txn(input vec_t v, output logic [31:0] rd, output logic er);
        int guard;
        @(negedge clk);
        n_acc = 0; fail_at = v.fail; lat = v.lat;
        req_addr = v.addr; req_write = v.wr; req_wdata = v.wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 ready low while busy", {31'b0, req_ready}, 32'h0);
        guard = 0;
        while (!rsp_done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        rd = rsp_rdata;
        er = rsp_error;
    endtask

    initial begin
        logic [31:0] rd;
        logic        er;
        logic [15:0] pg;
        logic [4:0]  lr;
        repeat (3) @(negedge clk);
        chk(req_ready && !acc_req && !rsp_done, "R1 state in reset",
            {29'b0, req_ready, acc_req, rsp_done}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !acc_req && !rsp_done, "R1 state after reset",
            {29'b0, req_ready, acc_req, rsp_done}, 32'h4);

        // Vector table
        foreach (VEC[i]) begin
            int exp_n;
            run_txn(VEC[i], rd, er);
            pg = {6'b0, VEC[i].addr[15:6]};
            lr = {1'b0, VEC[i].addr[5:2]};
            exp_n = (VEC[i].fail != 0) ? int'(VEC[i].fail) : 3;
            chk(n_acc == exp_n, "R7 access count", n_acc, exp_n);
            chk(log_phy[0] == 5'h1F, "R2 phy address", log_phy[0], 32'h1F);
            chk(log_reg[0] == 5'h1F && log_wr[0] && log_wd[0] == pg,
                "R3 page write", {log_reg[0], log_wr[0], log_wd[0]}, {5'h1F, 1'b1, pg});
            if (VEC[i].fail != 0) begin
                chk(er == 1'b1 && rd == 32'h0, "R7 error response", {er, rd[30:0]}, 32'h8000_0000);
            end else begin
                chk(er == 1'b0, "R7 no error", {31'b0, er}, 32'h0);
                chk(log_phy[1] == 5'h1F && log_phy[2] == 5'h1F, "R2 phy data steps",
                    {log_phy[1], log_phy[2]}, {5'h1F, 5'h1F});
                if (VEC[i].wr) begin
                    chk(log_reg[1] == lr && log_wr[1] && log_wd[1] == VEC[i].wdata[15:0],
                        "R6 low write", {log_reg[1], log_wr[1], log_wd[1]},
                        {lr, 1'b1, VEC[i].wdata[15:0]});
                    chk(log_reg[2] == 5'h10 && log_wr[2] && log_wd[2] == VEC[i].wdata[31:16],
                        "R6 high write", {log_reg[2], log_wr[2], log_wd[2]},
                        {5'h10, 1'b1, VEC[i].wdata[31:16]});
                    chk(rd == 32'h0, "R5 write rdata zero", rd, 32'h0);
                end else begin
                    chk(log_reg[1] == lr && !log_wr[1] && log_reg[2] == 5'h10 && !log_wr[2],
                        "R4 read order R8", {log_reg[1], log_wr[1], log_reg[2], log_wr[2]},
                        {lr, 1'b0, 5'h10, 1'b0});
                    chk(rd == {remote_val(pg, 5'h10), remote_val(pg, lr)}, "R5 read data",
                        rd, {remote_val(pg, 5'h10), remote_val(pg, lr)});
                end
            end
        end

        // Stray acknowledge while idle
        @(negedge clk);
        stray = 1'b1;
        repeat (3) @(negedge clk);
        chk(!acc_req && !rsp_done && req_ready, "R11 stray ack ignored",
            {29'b0, acc_req, rsp_done, req_ready}, 32'h1);

        // Completion and next acceptance in one cycle
        @(negedge clk);
        n_acc = 0; fail_at = 0; lat = 1;
        req_addr = 32'h0000_0084; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h0000_0A40; req_write = 1'b1; req_wdata = 32'h5555_AAAA;
        begin
            int guard = 0;
            while (!rsp_done && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        pg = 16'h0002; lr = 5'h01;
        chk(rsp_done && req_ready, "R9 done with ready", {30'b0, rsp_done, req_ready}, 32'h3);
        chk(rsp_rdata == {remote_val(pg, 5'h10), remote_val(pg, lr)}, "R9 first result kept",
            rsp_rdata, {remote_val(pg, 5'h10), remote_val(pg, lr)});
        @(negedge clk);
        req_valid = 1'b0;
        chk(acc_req && acc_write && acc_reg == 5'h1F && acc_wdata == 16'h0029,
            "R3 next page after back-to-back", {acc_req, acc_write, acc_reg, acc_wdata},
            {1'b1, 1'b1, 5'h1F, 16'h0029});
        chk(!rsp_done, "R9 done is one cycle", {31'b0, rsp_done}, 32'h0);
        begin
            int guard = 0;
            while (!rsp_done && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        chk(!rsp_error, "R7 second no error", {31'b0, rsp_error}, 32'h0);
        chk(stab_bad == 0, "R10 access held until ack", stab_bad, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule